// File: doc/BRIEF.md
# Register Rename Map with Result-Ready Flag

This block keeps, for every architectural register, the identity of the most recent in-flight instruction that will write it. That identity is a reorder-buffer number, called the producer tag. Tag zero is reserved: it means "no producer", so the committed value sits in the register file. Beside each tag the entry holds a ready flag. The flag tells whether the producer has already finished and left its result in the reorder buffer, even though that result has not yet retired.

Dispatch logic looks up two source registers per cycle. Each lookup returns the stored tag and one of three classes: read the register file, wait for a broadcast, or copy the finished value out of the reorder buffer. The same cycle may write one destination mapping.

Two other ports change entries that already exist. A completion port marks an entry ready, and a retirement port returns an entry to the register-file state. Both act only while the entry still names the instruction concerned. A flush returns every entry to the register-file state for precise recovery.

Top module: `renameMapTable`

## Requirements
- R1: After reset every entry holds tag 0 with the ready flag clear, so every lookup reports tag 0 and class 0.
- R2: A lookup reports the entry's tag and a 2-bit class:
  - 0 means the register file (tag 0).
  - 1 means pending (tag nonzero, ready flag clear).
  - 2 means ready in the reorder buffer (tag nonzero, ready flag set).
- R3: A dispatch write sets the destination entry to the given tag with the ready flag clear, visible from the next cycle.
- R4: A completion sets the ready flag of its register from the next cycle only if the entry holds the completing tag; otherwise the entry is unchanged.
- R5: A retirement sets its register's entry to tag 0 from the next cycle only if the entry holds the retiring tag; otherwise the entry is unchanged.
- R6: A flush sets every entry to tag 0 from the next cycle, overriding any dispatch, completion or retirement in the same cycle.
- R7: When dispatch and a completion or retirement name the same register in one cycle, the dispatch result is what the entry holds next.
- R8: Lookups see the table as it stood before this cycle's dispatch write, so a source equal to the same-cycle destination reads the older mapping.
- R9: A matching completion in the same cycle as a lookup of that register makes the lookup report class 2.
- R10: A matching completion and a matching retirement of the same entry in one cycle leave the entry at tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear every mapping |
| dispValid | input | 1 | Dispatch write enable |
| dispDst | input | 4 | Dispatch destination register |
| dispTag | input | 4 | Allocated reorder-buffer number (nonzero) |
| cmpValid | input | 1 | Completion strobe |
| cmpDst | input | 4 | Completing instruction's destination register |
| cmpTag | input | 4 | Completing reorder-buffer number |
| retValid | input | 1 | Retirement strobe |
| retDst | input | 4 | Retiring instruction's destination register |
| retTag | input | 4 | Retiring reorder-buffer number |
| srcA | input | 4 | First lookup register |
| srcB | input | 4 | Second lookup register |
| tagA | output | 4 | Tag for srcA |
| stateA | output | 2 | Class for srcA |
| tagB | output | 4 | Tag for srcB |
| stateB | output | 2 | Class for srcB |

## Verification
The hardest case to reach from the ports is the stale update. This is a completion or retirement that names a tag its register no longer holds, because a younger dispatch has remapped the register in between.

Random stimulus seldom reaches it, so the stimulus draws half of the completion and retirement tags from the reference model's current mapping and half at random. Directed sequences remap a register and then complete or retire its old tag. Further directed cycles put dispatch, completion, retirement and flush on the same register in the same cycle, so that every priority rule is exercised.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  // Lookup classification
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_PENDING = 2'd1,
    SRC_INROB   = 2'd2
  } srcState_e;

  // Per-entry strobes from control to datapath, mutually exclusive
  typedef struct packed {
    logic load;  // take dispatch tag, clear ready
    logic wipe;  // back to tag 0
    logic mark;  // set ready flag
  } entryStrb_t;
endpackage

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
  import rmt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                            flush,
  input  logic                            dispValid,
  input  logic [AW-1:0]                   dispDst,
  input  logic                            cmpValid,
  input  logic [AW-1:0]                   cmpDst,
  input  logic [TAG_W-1:0]                cmpTag,
  input  logic                            retValid,
  input  logic [AW-1:0]                   retDst,
  input  logic [TAG_W-1:0]                retTag,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  entryTag,
  output entryStrb_t [NUM_REGS-1:0]       strb
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    logic hitDisp, hitCmp, hitRet;
    always_comb begin
      hitDisp = dispValid && (dispDst == AW'(i));
      hitCmp  = cmpValid && (cmpDst == AW'(i)) && (cmpTag != '0)
                && (entryTag[i] == cmpTag);
      hitRet  = retValid && (retDst == AW'(i)) && (retTag != '0)
                && (entryTag[i] == retTag);
      // priority: flush > dispatch > retirement > completion
      strb[i].load = !flush && hitDisp;
      strb[i].wipe = flush || (!hitDisp && hitRet);
      strb[i].mark = !flush && !hitDisp && !hitRet && hitCmp;
    end
  end
endmodule

// File: rtl/rmt_datapath.sv
module rmt_datapath
  import rmt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  entryStrb_t [NUM_REGS-1:0]       strb,
  input  logic [TAG_W-1:0]                dispTag,
  input  logic                            cmpValid,
  input  logic [AW-1:0]                   cmpDst,
  input  logic [TAG_W-1:0]                cmpTag,
  input  logic [NUM_RD-1:0][AW-1:0]       srcReg,
  output logic [NUM_RD-1:0][TAG_W-1:0]    srcTag,
  output srcState_e [NUM_RD-1:0]          srcState,
  output logic [NUM_REGS-1:0][TAG_W-1:0]  entryTag,
  output logic [NUM_REGS-1:0]             entryRdy
);
  // Storage
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryTag[i] <= '0;
        entryRdy[i] <= 1'b0;
      end else if (strb[i].load) begin
        entryTag[i] <= dispTag;
        entryRdy[i] <= 1'b0;
      end else if (strb[i].wipe) begin
        entryTag[i] <= '0;
        entryRdy[i] <= 1'b0;
      end else if (strb[i].mark) begin
        entryRdy[i] <= 1'b1;
      end
    end
  end

  // Lookup ports: read pre-update state, bypass same-cycle completion
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [TAG_W-1:0] curTag;
    logic             bypass;
    always_comb begin
      curTag    = entryTag[srcReg[p]];
      bypass    = cmpValid && (cmpDst == srcReg[p]) && (cmpTag == curTag);
      srcTag[p] = curTag;
      if (curTag == '0)                       srcState[p] = SRC_REGFILE;
      else if (entryRdy[srcReg[p]] || bypass) srcState[p] = SRC_INROB;
      else                                    srcState[p] = SRC_PENDING;
    end
    // R2: class 0 exactly when the reported tag is zero
    always_comb begin
      if (rstN) begin
        p_class_zero_r2: assert ((srcState[p] == SRC_REGFILE) == (srcTag[p] == '0))
          else $error("lookup class disagrees with tag");
      end
    end
  end
endmodule

// File: rtl/renameMapTable.sv
module renameMapTable
  import rmt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             dispValid,
  input  logic [AW-1:0]    dispDst,
  input  logic [TAG_W-1:0] dispTag,
  input  logic             cmpValid,
  input  logic [AW-1:0]    cmpDst,
  input  logic [TAG_W-1:0] cmpTag,
  input  logic             retValid,
  input  logic [AW-1:0]    retDst,
  input  logic [TAG_W-1:0] retTag,
  input  logic [AW-1:0]    srcA,
  input  logic [AW-1:0]    srcB,
  output logic [TAG_W-1:0] tagA,
  output logic [1:0]       stateA,
  output logic [TAG_W-1:0] tagB,
  output logic [1:0]       stateB
);
  entryStrb_t [NUM_REGS-1:0]      strb;
  logic [NUM_REGS-1:0][TAG_W-1:0] entryTag;
  logic [NUM_REGS-1:0]            entryRdy;
  logic [1:0][AW-1:0]             srcReg;
  logic [1:0][TAG_W-1:0]          srcTag;
  srcState_e [1:0]                srcState;

  assign srcReg = {srcB, srcA};

  rmt_ctrl #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) ctrl_i (
    .flush(flush), .dispValid(dispValid), .dispDst(dispDst),
    .cmpValid(cmpValid), .cmpDst(cmpDst), .cmpTag(cmpTag),
    .retValid(retValid), .retDst(retDst), .retTag(retTag),
    .entryTag(entryTag), .strb(strb)
  );

  rmt_datapath #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_RD(2)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dispTag(dispTag),
    .cmpValid(cmpValid), .cmpDst(cmpDst), .cmpTag(cmpTag),
    .srcReg(srcReg), .srcTag(srcTag), .srcState(srcState),
    .entryTag(entryTag), .entryRdy(entryRdy)
  );

  assign tagA   = srcTag[0];
  assign stateA = srcState[0];
  assign tagB   = srcTag[1];
  assign stateB = srcState[1];

  // R3: dispatch lands with ready clear
  p_disp_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !flush) |=>
      (entryTag[$past(dispDst)] == $past(dispTag)) && !entryRdy[$past(dispDst)]);

  // R4: a completion whose tag no longer matches leaves the entry alone
  p_cmp_stale_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !flush && !(dispValid && dispDst == cmpDst)
     && !(retValid && retDst == cmpDst) && entryTag[cmpDst] != cmpTag) |=>
      (entryTag[$past(cmpDst)] == $past(entryTag[cmpDst]))
      && (entryRdy[$past(cmpDst)] == $past(entryRdy[cmpDst])));

  // R5: a matching retirement frees the entry
  p_ret_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retTag != '0 && entryTag[retDst] == retTag
     && !(dispValid && dispDst == retDst)) |=>
      (entryTag[$past(retDst)] == '0) && !entryRdy[$past(retDst)]);

  // R6: flush empties the table
  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (entryTag == '0) && (entryRdy == '0));
endmodule

// File: tb/renameMapTable_tb_top.sv
module renameMapTable_tb_top;
  localparam int NR = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rstN;
  logic flush, dispValid, cmpValid, retValid;
  logic [3:0] dispDst, cmpDst, retDst, srcA, srcB;
  logic [TW-1:0] dispTag, cmpTag, retTag, tagA, tagB;
  logic [1:0] stateA, stateB;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int mTag[NR];
  bit mRdy[NR];

  always #5 clk = ~clk;

  renameMapTable #(.NUM_REGS(NR), .TAG_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispValid(dispValid), .dispDst(dispDst), .dispTag(dispTag),
    .cmpValid(cmpValid), .cmpDst(cmpDst), .cmpTag(cmpTag),
    .retValid(retValid), .retDst(retDst), .retTag(retTag),
    .srcA(srcA), .srcB(srcB),
    .tagA(tagA), .stateA(stateA), .tagB(tagB), .stateB(stateB)
  );

  task automatic check(input string rq, input string port, input int aTag, input int aSt,
                       input int eTag, input int eSt);
    total++;
    if (aTag != eTag || aSt != eSt) begin
      bad++;
      $display("FAIL %s port %s: tag=%0d class=%0d expected tag=%0d class=%0d",
               rq, port, aTag, aSt, eTag, eSt);
    end
  endtask

  function automatic int expClass(input int r, input bit cv, input int cd, input int ct);
    if (mTag[r] == 0) return 0;
    if (mRdy[r] || (cv && cd == r && ct == mTag[r])) return 2;
    return 1;
  endfunction

  // Drive one cycle, check lookups, then advance the reference model.
  task automatic step(input string rq, input bit fl,
                      input bit dv, input int dd, input int dt,
                      input bit cv, input int cd, input int ct,
                      input bit rv, input int rd, input int rt,
                      input int sa, input int sb);
    @(negedge clk);
    flush = fl; dispValid = dv; dispDst = 4'(dd); dispTag = 4'(dt);
    cmpValid = cv; cmpDst = 4'(cd); cmpTag = 4'(ct);
    retValid = rv; retDst = 4'(rd); retTag = 4'(rt);
    srcA = 4'(sa); srcB = 4'(sb);
    #2;
    check(rq, "A", int'(tagA), int'(stateA), mTag[sa], expClass(sa, cv, cd, ct));
    check(rq, "B", int'(tagB), int'(stateB), mTag[sb], expClass(sb, cv, cd, ct));
    if (cv && ct != 0 && mTag[cd] == ct) mRdy[cd] = 1;
    if (rv && rt != 0 && mTag[rd] == rt) begin mTag[rd] = 0; mRdy[rd] = 0; end
    if (dv) begin mTag[dd] = dt; mRdy[dd] = 0; end
    if (fl) for (int i = 0; i < NR; i++) begin mTag[i] = 0; mRdy[i] = 0; end
  endtask

  task automatic look(input string rq, input int sa, input int sb);
    step(rq, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, sa, sb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mTag[i] = 0; mRdy[i] = 0; end
    rstN = 1'b0; flush = 0; dispValid = 0; cmpValid = 0; retValid = 0;
    dispDst = 0; dispTag = 0; cmpDst = 0; cmpTag = 0; retDst = 0; retTag = 0;
    srcA = 0; srcB = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state of every entry
    for (int r = 0; r < NR; r += 2) look("R1", r, r + 1);

    // R8: same-cycle dispatch not visible; R3: visible next cycle as pending
    step("R8", 0, 1, 3, 5, 0, 0, 0, 0, 0, 0, 3, 3);
    look("R3", 3, 0);
    // R9: completion bypassed into lookup; R4: ready held afterwards
    step("R9", 0, 0, 0, 0, 1, 3, 5, 0, 0, 0, 3, 4);
    look("R4", 3, 3);
    // R4: stale completion after remap does nothing
    step("R3", 0, 1, 3, 7, 0, 0, 0, 0, 0, 0, 3, 3);
    step("R4", 0, 0, 0, 0, 1, 3, 5, 0, 0, 0, 3, 3);
    look("R4", 3, 3);
    // R7: dispatch beats completion and retirement on one register
    step("R7", 0, 1, 3, 9, 1, 3, 7, 1, 3, 7, 3, 3);
    look("R7", 3, 3);
    // R5: matching retirement frees the entry
    step("R5", 0, 0, 0, 0, 1, 3, 9, 0, 0, 0, 3, 3);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 3, 9, 3, 3);
    look("R5", 3, 3);
    // R5: stale retirement keeps the mapping
    step("R5", 0, 1, 4, 2, 0, 0, 0, 0, 0, 0, 4, 4);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 4, 3, 4, 4);
    look("R5", 4, 4);
    // R10: matching completion and retirement together free the entry
    step("R10", 0, 1, 6, 4, 0, 0, 0, 0, 0, 0, 6, 6);
    step("R10", 0, 0, 0, 0, 1, 6, 4, 1, 6, 4, 6, 6);
    look("R10", 6, 6);
    // R6: flush overrides a same-cycle dispatch
    step("R6", 0, 1, 8, 11, 0, 0, 0, 0, 0, 0, 8, 4);
    step("R6", 1, 1, 9, 12, 1, 8, 11, 0, 0, 0, 8, 9);
    for (int r = 0; r < NR; r += 2) look("R6", r, r + 1);

    // R2: random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      int dd, dt, cd, ct, rd, rt, sa, sb;
      bit fl, dv, cv, rv;
      fl = ($urandom_range(0, 99) == 0);
      dv = $urandom_range(0, 1);
      cv = $urandom_range(0, 1);
      rv = ($urandom_range(0, 2) == 0);
      dd = $urandom_range(0, NR - 1);
      dt = $urandom_range(1, 15);
      cd = $urandom_range(0, NR - 1);
      rd = $urandom_range(0, NR - 1);
      ct = $urandom_range(0, 1) ? mTag[cd] : $urandom_range(0, 15);
      rt = $urandom_range(0, 1) ? mTag[rd] : $urandom_range(0, 15);
      sa = $urandom_range(0, 2) == 0 ? cd : $urandom_range(0, NR - 1);
      sb = $urandom_range(0, 2) == 0 ? dd : $urandom_range(0, NR - 1);
      step("R2", fl, dv, dd, dt, cv, cd, ct, rv, rd, rt, sa, sb);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule